// File: doc/BRIEF.md
# Branch Trace Record Controller

This block collects control-flow records (taken branches, interrupts and exceptions), each a source address, a destination address and a two-bit kind. It keeps them in an on-chip record buffer, sends each one out as a trace message on a valid/ready port, or does both. A branch and an interrupt or exception that arrive in the same cycle produce two records, the branch first.

A small state machine handles capture. ST_IDLE takes a new event (transition T_ACCEPT). ST_FIRST commits the first pending record (T_NEXT leads to ST_SECOND when a second record is pending, T_DONE1 returns to ST_IDLE when none is). ST_SECOND commits the second record (T_DONE2 returns to ST_IDLE). In either commit state, a message that is not yet accepted keeps the state where it is (T_WAIT).

The buffer runs in one of two modes. In circular mode it wraps and keeps the newest DEPTH records. In threshold mode it stops at full until software clears the write index, and it can raise a level interrupt once the fill reaches a programmable threshold. The EXCLUSIVE parameter picks one of two configurations. In the exclusive one, storage is blocked while messages are enabled. In the concurrent one, both paths run together.

Top module: `btrace_ctl`

## Requirements
- R1: After reset, in_ready is 1, msg_valid is 0, irq is 0, rec_count is 0 and wr_idx is 0.
- R2: When br_valid and xc_valid are accepted together, two records are produced in order: the branch record first, then the interrupt/exception record.
- R3: Control bit 0 enables storage. While it is 0, accepted events leave the buffer contents, rec_count and wr_idx unchanged.
- R4: Control bit 6 enables messages. While it is 1, every record appears once on msg_data with msg_valid, in production order.
- R5: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1, msg_data stays stable and in_ready stays 0. No record is lost.
- R6: With control bit 2 = 0 (circular), the buffer writes slots 0 to DEPTH-1 and then wraps to slot 0, overwriting the oldest record. rec_count saturates at DEPTH.
- R7: With control bit 2 = 1 (threshold), no further record is stored once rec_count equals DEPTH. A pulse on idx_clr sets rec_count and wr_idx to 0, and storing then resumes.
- R8: With control bit 8 = 1 in threshold mode, irq rises when a stored record brings rec_count to the programmed threshold or above. It stays 1 until an irq_clr pulse.
- R9: With EXCLUSIVE=1 and control bit 6 set, records are not stored. With EXCLUSIVE=0 they are stored and sent.
- R10: A record is packed as {kind[1:0], from, to}, with kind 0 = branch, 1 = interrupt, 2 = exception (xc_kind 0 selects interrupt, 1 selects exception). rd_data returns the record held in slot rd_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 9 | Control value: bit 0 store, bit 2 threshold mode, bit 6 message, bit 8 interrupt enable |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | $clog2(DEPTH+1) | Threshold fill level |
| idx_clr | input | 1 | Clears write index and fill count |
| irq_clr | input | 1 | Clears the interrupt |
| br_valid | input | 1 | Taken branch present |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| xc_valid | input | 1 | Interrupt or exception present |
| xc_kind | input | 1 | 0 interrupt, 1 exception |
| xc_from | input | AW | Interrupted address |
| xc_to | input | AW | Handler address |
| in_ready | output | 1 | Event accepted this cycle when high |
| msg_valid | output | 1 | Trace message valid |
| msg_ready | input | 1 | Trace message accepted |
| msg_data | output | 2+2*AW | Trace message record |
| rd_idx | input | $clog2(DEPTH) | Readout slot |
| rd_data | output | 2+2*AW | Record held in slot rd_idx |
| wr_idx | output | $clog2(DEPTH+1) | Next slot to be written |
| rec_count | output | $clog2(DEPTH+1) | Number of valid records |
| irq | output | 1 | Threshold interrupt, level |

## Verification
The bench builds two instances that share all inputs, with AW=8 and DEPTH=4: one with EXCLUSIVE=1 and one with EXCLUSIVE=0. The small depth makes wrap-around, saturation at full and the threshold crossing reachable within a few events. The second instance lets one stimulus stream show storage suppressed in the exclusive configuration and kept in the concurrent one.

// File: rtl/btr_pkg.sv
package btr_pkg;
    typedef enum logic [1:0] {
        K_BRANCH = 2'd0,
        K_INTR   = 2'd1,
        K_EXCP   = 2'd2
    } rec_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_e;

    localparam int CFG_W      = 9;
    localparam int CFG_STORE  = 0;
    localparam int CFG_THRESH = 2;
    localparam int CFG_MSG    = 6;
    localparam int CFG_IRQ    = 8;
endpackage

// File: rtl/btr_seq.sv
module btr_seq
    import btr_pkg::*;
#(
    parameter int AW = 32,
    localparam int RW = 2 + 2 * AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_valid,
    input  logic [AW-1:0] br_from,
    input  logic [AW-1:0] br_to,
    input  logic          xc_valid,
    input  logic          xc_kind,
    input  logic [AW-1:0] xc_from,
    input  logic [AW-1:0] xc_to,
    output logic          in_ready,
    input  logic          msg_on,
    output logic          msg_valid,
    input  logic          msg_ready,
    output logic [RW-1:0] msg_data,
    output logic          commit,
    output logic [RW-1:0] commit_data
);
    seq_state_e state_q, state_d;
    logic [RW-1:0] pend0_q, pend1_q;
    logic          two_q;
    logic          accept;
    logic [RW-1:0] br_rec, xc_rec, head;

    assign br_rec = {K_BRANCH, br_from, br_to};
    assign xc_rec = {(xc_kind ? K_EXCP : K_INTR), xc_from, xc_to};
    assign accept = in_ready && (br_valid || xc_valid);

    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        head      = (state_q == ST_SECOND) ? pend1_q : pend0_q;
        msg_valid = !in_ready && msg_on;
        commit    = !in_ready && (!msg_on || msg_ready);
        msg_data    = head;
        commit_data = head;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_FIRST;
            ST_FIRST:  if (commit) state_d = two_q ? ST_SECOND : ST_IDLE;
            ST_SECOND: if (commit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend0_q <= '0;
            pend1_q <= '0;
            two_q   <= 1'b0;
        end else if (accept) begin
            pend0_q <= br_valid ? br_rec : xc_rec;
            pend1_q <= xc_rec;
            two_q   <= br_valid && xc_valid;
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data)));
    assert_no_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !in_ready);
    assert_pair_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && br_valid && xc_valid) |=> (commit_data[RW-1 -: 2] == K_BRANCH));
endmodule

// File: rtl/btr_store.sv
module btr_store #(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    localparam int RW = 2 + 2 * AW,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    input  logic          mode_thr,
    input  logic          irq_en,
    input  logic [CW-1:0] thr,
    input  logic          idx_clr,
    input  logic          irq_clr,
    input  logic [IW-1:0] rd_idx,
    output logic [RW-1:0] rd_data,
    output logic [CW-1:0] wr_idx,
    output logic [CW-1:0] count,
    output logic          irq
);
    localparam logic [CW-1:0] LAST  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic [RW-1:0] mem [DEPTH];
    logic [CW-1:0] wptr_q, cnt_q, cnt_inc;
    logic          irq_q, full, do_wr;

    assign full    = (cnt_q == FULLV);
    assign do_wr   = wr_en && !(mode_thr && full);
    assign cnt_inc = full ? FULLV : cnt_q + CW'(1);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr_q[IW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            cnt_q  <= '0;
        end else if (idx_clr) begin
            wptr_q <= '0;
            cnt_q  <= '0;
        end else if (do_wr) begin
            cnt_q <= cnt_inc;
            if (!mode_thr && wptr_q >= LAST) wptr_q <= '0;
            else                             wptr_q <= wptr_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                           irq_q <= 1'b0;
        else if (do_wr && mode_thr && irq_en && cnt_inc >= thr) irq_q <= 1'b1;
        else if (irq_clr)                                     irq_q <= 1'b0;
    end

    assign rd_data = (32'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
    assign wr_idx  = wptr_q;
    assign count   = cnt_q;
    assign irq     = irq_q;

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULLV);
    assert_full_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_thr && full && !idx_clr) |=> (cnt_q == FULLV && $stable(wptr_q)));
    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q);
endmodule

// File: rtl/btrace_ctl.sv
module btrace_ctl
    import btr_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DEPTH     = 16,
    parameter bit EXCLUSIVE = 1'b1,
    localparam int RW = 2 + 2 * AW,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             thr_we,
    input  logic [CW-1:0]    thr_wdata,
    input  logic             idx_clr,
    input  logic             irq_clr,
    input  logic             br_valid,
    input  logic [AW-1:0]    br_from,
    input  logic [AW-1:0]    br_to,
    input  logic             xc_valid,
    input  logic             xc_kind,
    input  logic [AW-1:0]    xc_from,
    input  logic [AW-1:0]    xc_to,
    output logic             in_ready,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [RW-1:0]    msg_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [RW-1:0]    rd_data,
    output logic [CW-1:0]    wr_idx,
    output logic [CW-1:0]    rec_count,
    output logic             irq
);
    logic          store_en_q, thr_mode_q, msg_en_q, irq_en_q;
    logic [CW-1:0] thr_q;
    logic          commit, store_on, store_we;
    logic [RW-1:0] commit_data;
    logic          cfg_unused_bits;

    assign cfg_unused_bits = ^{cfg_wdata[7], cfg_wdata[5:3], cfg_wdata[1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_en_q <= 1'b0;
            thr_mode_q <= 1'b0;
            msg_en_q   <= 1'b0;
            irq_en_q   <= 1'b0;
        end else if (cfg_we) begin
            store_en_q <= cfg_wdata[CFG_STORE];
            thr_mode_q <= cfg_wdata[CFG_THRESH];
            msg_en_q   <= cfg_wdata[CFG_MSG];
            irq_en_q   <= cfg_wdata[CFG_IRQ];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_q <= CW'(DEPTH);
        else if (thr_we) thr_q <= thr_wdata;
    end

    generate
        if (EXCLUSIVE) begin : g_excl
            assign store_on = store_en_q && !msg_en_q;
        end else begin : g_conc
            assign store_on = store_en_q;
        end
    endgenerate

    assign store_we = commit && store_on;

    btr_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .xc_valid(xc_valid), .xc_kind(xc_kind), .xc_from(xc_from), .xc_to(xc_to),
        .in_ready(in_ready), .msg_on(msg_en_q), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_data(msg_data),
        .commit(commit), .commit_data(commit_data)
    );

    btr_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(store_we), .wr_data(commit_data),
        .mode_thr(thr_mode_q), .irq_en(irq_en_q), .thr(thr_q),
        .idx_clr(idx_clr), .irq_clr(irq_clr),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_idx(wr_idx), .count(rec_count), .irq(irq)
    );

    assert_store_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_en_q && !idx_clr) |=> $stable(rec_count));
    generate
        if (EXCLUSIVE) begin : g_excl_chk
            assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (msg_en_q && !idx_clr) |=> $stable(rec_count) && $stable(wr_idx));
        end
    endgenerate
endmodule

// File: tb/test_btrace_ctl.sv
module test_btrace_ctl;
    localparam int AW = 8;
    localparam int DEPTH = 4;
    localparam int RW = 2 + 2 * AW;
    localparam int IW = 2;
    localparam int CW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, thr_we = 0, idx_clr = 0, irq_clr = 0;
    logic [8:0] cfg_wdata = '0;
    logic [CW-1:0] thr_wdata = '0;
    logic br_valid = 0, xc_valid = 0, xc_kind = 0, msg_ready = 1;
    logic [AW-1:0] br_from = 0, br_to = 0, xc_from = 0, xc_to = 0;
    logic [IW-1:0] rd_idx = '0;
    logic in_ready [2];
    logic msg_valid [2];
    logic [RW-1:0] msg_data [2];
    logic [RW-1:0] rd_data [2];
    logic [CW-1:0] wr_idx [2];
    logic [CW-1:0] rec_count [2];
    logic irq [2];

    always #4 clk = ~clk;

    btrace_ctl #(.AW(AW), .DEPTH(DEPTH), .EXCLUSIVE(1'b1)) i_btrace_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .idx_clr(idx_clr), .irq_clr(irq_clr),
        .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .xc_valid(xc_valid), .xc_kind(xc_kind), .xc_from(xc_from), .xc_to(xc_to),
        .in_ready(in_ready[0]), .msg_valid(msg_valid[0]), .msg_ready(msg_ready),
        .msg_data(msg_data[0]), .rd_idx(rd_idx), .rd_data(rd_data[0]),
        .wr_idx(wr_idx[0]), .rec_count(rec_count[0]), .irq(irq[0]));

    btrace_ctl #(.AW(AW), .DEPTH(DEPTH), .EXCLUSIVE(1'b0)) i_btrace_ctl_conc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .idx_clr(idx_clr), .irq_clr(irq_clr),
        .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .xc_valid(xc_valid), .xc_kind(xc_kind), .xc_from(xc_from), .xc_to(xc_to),
        .in_ready(in_ready[1]), .msg_valid(msg_valid[1]), .msg_ready(msg_ready),
        .msg_data(msg_data[1]), .rd_idx(rd_idx), .rd_data(rd_data[1]),
        .wr_idx(wr_idx[1]), .rec_count(rec_count[1]), .irq(irq[1]));

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit c_store = 0, c_thr = 0, c_msg = 0, c_irq = 0;
    int c_thv = DEPTH;
    logic [RW-1:0] m_mem [2][DEPTH];
    int m_w [2];
    int m_cnt [2];
    bit m_irq [2];
    logic [RW-1:0] exp_q [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_rec(input logic [RW-1:0] r);
        if (c_msg) exp_q.push_back(r);
        for (int i = 0; i < 2; i++) begin
            bit on = c_store && !(i == 0 && c_msg);
            if (on) begin
                if (!c_thr) begin
                    m_mem[i][m_w[i]] = r;
                    m_w[i] = (m_w[i] + 1) % DEPTH;
                    if (m_cnt[i] < DEPTH) m_cnt[i]++;
                end else if (m_cnt[i] < DEPTH) begin
                    m_mem[i][m_w[i]] = r;
                    m_w[i]++;
                    m_cnt[i]++;
                    if (c_irq && m_cnt[i] >= c_thv) m_irq[i] = 1;
                end
            end
        end
    endtask

    task automatic write_cfg(input bit st, input bit th, input bit ms, input bit iq);
        @(negedge clk);
        cfg_we = 1;
        cfg_wdata = '0;
        cfg_wdata[0] = st; cfg_wdata[2] = th; cfg_wdata[6] = ms; cfg_wdata[8] = iq;
        @(negedge clk);
        cfg_we = 0;
        c_store = st; c_thr = th; c_msg = ms; c_irq = iq;
    endtask

    task automatic pulse_idx_clr();
        @(negedge clk); idx_clr = 1;
        @(negedge clk); idx_clr = 0;
        for (int i = 0; i < 2; i++) begin m_w[i] = 0; m_cnt[i] = 0; end
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        for (int i = 0; i < 2; i++) m_irq[i] = 0;
    endtask

    task automatic offer(input bit bv, input logic [AW-1:0] bf, input logic [AW-1:0] bt,
                         input bit xv, input bit xk, input logic [AW-1:0] xf, input logic [AW-1:0] xt);
        @(negedge clk);
        br_valid = bv; br_from = bf; br_to = bt;
        xc_valid = xv; xc_kind = xk; xc_from = xf; xc_to = xt;
        while (!in_ready[0]) @(negedge clk);
        @(negedge clk);
        br_valid = 0; xc_valid = 0;
        if (bv) model_rec({2'd0, bf, bt});
        if (xv) model_rec({(xk ? 2'd2 : 2'd1), xf, xt});
    endtask

    task automatic wait_idle();
        while (!in_ready[0]) @(negedge clk);
    endtask

    task automatic send(input bit bv, input logic [AW-1:0] bf, input logic [AW-1:0] bt,
                        input bit xv, input bit xk, input logic [AW-1:0] xf, input logic [AW-1:0] xt);
        offer(bv, bf, bt, xv, xk, xf, xt);
        wait_idle();
    endtask

    task automatic check_state(input string tag);
        for (int i = 0; i < 2; i++) begin
            chk(rec_count[i] == CW'(m_cnt[i]), {tag, " count"}, rec_count[i], m_cnt[i]);
            chk(wr_idx[i] == CW'(m_w[i]), {tag, " wr_idx"}, wr_idx[i], m_w[i]);
            chk(irq[i] == m_irq[i], {tag, " irq"}, irq[i], m_irq[i]);
            for (int k = 0; k < DEPTH; k++) begin
                if (k < m_cnt[i]) begin
                    rd_idx = IW'(k);
                    #1;
                    chk(rd_data[i] === m_mem[i][k], {tag, " slot R10"}, rd_data[i], m_mem[i][k]);
                end
            end
        end
    endtask

    // R4 R10: every message handshake compared with the expected queue
    always @(negedge clk) begin
        if (rst_n && msg_valid[0] && msg_ready) begin
            if (exp_q.size() == 0) chk(0, "R4 unexpected message", msg_data[0], 0);
            else begin
                logic [RW-1:0] e;
                e = exp_q.pop_front();
                chk(msg_data[0] === e, "R4 message", msg_data[0], e);
                chk(msg_data[1] === e, "R4 message conc", msg_data[1], e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_w[i] = 0; m_cnt[i] = 0; m_irq[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready[0] == 1, "R1 in_ready", in_ready[0], 1);
        chk(msg_valid[0] == 0, "R1 msg_valid", msg_valid[0], 0);
        check_state("R1");

        // R6 R2 R10 circular storage, pair ordering, wrap
        write_cfg(1, 0, 0, 0);
        send(1, 8'h10, 8'h20, 0, 0, 0, 0);
        send(0, 0, 0, 1, 0, 8'h21, 8'h80);
        send(1, 8'h30, 8'h40, 1, 1, 8'h40, 8'h90);
        check_state("R2");
        send(1, 8'h50, 8'h60, 0, 0, 0, 0);
        send(1, 8'h61, 8'h70, 1, 0, 8'h70, 8'hA0);
        check_state("R6 wrap");

        // R3 storage disabled
        write_cfg(0, 0, 0, 0);
        send(1, 8'hEE, 8'hEF, 1, 1, 8'hEF, 8'hF0);
        check_state("R3");

        // R7 R8 threshold mode and interrupt
        pulse_idx_clr();
        @(negedge clk); thr_we = 1; thr_wdata = 3'd3;
        @(negedge clk); thr_we = 0; c_thv = 3;
        write_cfg(1, 1, 0, 1);
        send(1, 8'h01, 8'h02, 1, 0, 8'h02, 8'h03);
        check_state("R8 below");
        send(1, 8'h04, 8'h05, 0, 0, 0, 0);
        check_state("R8 reach");
        send(1, 8'h06, 8'h07, 1, 1, 8'h07, 8'h08);
        check_state("R7 full");
        send(1, 8'h09, 8'h0A, 0, 0, 0, 0);
        check_state("R7 stopped");
        pulse_irq_clr();
        check_state("R8 clear");
        pulse_idx_clr();
        check_state("R7 cleared");
        send(0, 0, 0, 1, 1, 8'h0B, 8'h0C);
        check_state("R7 resume");

        // R9 R4 messages with both paths
        pulse_idx_clr();
        write_cfg(1, 0, 1, 0);
        send(1, 8'h11, 8'h12, 1, 1, 8'h12, 8'h13);
        check_state("R9");

        // R5 backpressure
        @(negedge clk); msg_ready = 0;
        offer(1, 8'h21, 8'h22, 1, 0, 8'h22, 8'h23);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(msg_valid[0] == 1, "R5 valid held", msg_valid[0], 1);
            chk(msg_data[0] === {2'd0, 8'h21, 8'h22}, "R5 data held", msg_data[0], {2'd0, 8'h21, 8'h22});
            chk(in_ready[0] == 0, "R5 no accept", in_ready[0], 0);
        end
        msg_ready = 1;
        wait_idle();
        @(negedge clk);
        chk(exp_q.size() == 0, "R5 R4 all delivered", exp_q.size(), 0);
        check_state("R9 R5");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule